// File: doc/BRIEF.md
# Fetch Next-Address Predictor

This block guesses, in the same cycle as the fetch address arrives, whether the instruction at that address redirects fetch and where fetch should go next. A small direct-mapped target table, indexed and tagged by the fetch address, supplies a two-bit confidence counter and a remembered target before the instruction is decoded. When the table has no entry for the address, a fixed rule based on the decode-stage branch descriptor is used instead. Subroutine returns are steered by a separate circular stack of return addresses that calls fill and returns drain.

The table is trained only from the retirement port, with the resolved direction and target of a committed branch. The lookup path never writes it. A flush input empties the return stack after a pipeline redirect and leaves the trained table as it is.

Top module: `fetch_predictor`

## Requirements
- R1: Lookup is combinational on `lookupAddr`. The low log2(BTB_ENTRIES) bits select the entry and the remaining upper bits must equal the stored tag for a hit. After reset no entry hits, and a lookup with no branch descriptor (`brValid`=0) that misses predicts not taken with target `lookupAddr + brLen`.
- R2: On a hit, the prediction is taken when the entry's counter is 2 or 3, with the stored target. With a counter of 0 or 1 the prediction is not taken with target `lookupAddr + brLen`. A hit overrides the descriptor-based rule.
- R3: On a miss with a descriptor, `brKind` 2'b00 (conditional) predicts taken exactly when `brBackward` is 1. Kinds 2'b01 (call) and 2'b11 (jump) predict taken. A taken prediction uses `brTarget`, and a not-taken one uses `lookupAddr + brLen`.
- R4: Only a retirement (`retValid`) changes the table. A retirement that misses allocates the entry with counter 2 if taken or 1 if not taken, and stores `retTarget`. One that hits moves the counter up (taken) or down (not taken), saturating at 3 and 0, and stores `retTarget` when taken.
- R5: A return (`brKind` 2'b10) always predicts taken. While the stack is non-empty, its target is the top of the stack.
- R6: A call pushes `lookupAddr + brLen` and a return with a non-empty stack pops it, so nested calls and returns come back in last-in, first-out order.
- R7: The stack holds RAS_DEPTH entries and wraps. Once it is full, a further push overwrites the oldest entry, so after ten calls with depth 8 the next eight returns yield the last eight calls.
- R8: A return on an empty stack takes the table's stored target if the address hits, or `lookupAddr + brLen` if it misses.
- R9: `flush` empties the return stack. A call in the same cycle is not pushed, and table contents are unchanged.
- R10: When a retirement and a lookup address the same entry in one cycle, the lookup sees the entry as it was before that cycle. The write is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the return stack |
| lookupValid | input | 1 | Fetch address is valid this cycle |
| lookupAddr | input | AW | Address of the instruction being fetched |
| brValid | input | 1 | Branch descriptor is present |
| brKind | input | 2 | 00 conditional, 01 call, 10 return, 11 jump |
| brBackward | input | 1 | Static target is at a lower address |
| brTarget | input | AW | Target computed from the displacement |
| brLen | input | LENW | Instruction length in address units |
| retValid | input | 1 | A branch retires this cycle |
| retAddr | input | AW | Address of the retiring branch |
| retTaken | input | 1 | Resolved direction |
| retTarget | input | AW | Resolved target |
| predTaken | output | 1 | Predicted redirect |
| predTarget | output | AW | Predicted next fetch address |

## Verification
The prediction is combinational, so it is due in the same cycle as the lookup inputs. The bench drives each pattern just after a falling edge and samples both outputs one nanosecond later, before the next rising edge. Table training, stack pushes and pops, and flush take effect at the rising edge that follows the cycle in which they are driven. Their effects are therefore checked on a lookup in the next cycle, and the same-cycle case of R10 is sampled in the cycle of the write itself, where it must still show the old entry. Counter sequences and stack contents are computed in the bench with saturating arithmetic and an address list, and are never read from the design.

// File: rtl/fp_pkg.sv
package fp_pkg;

  typedef enum logic [1:0] {
    KIND_COND = 2'b00,
    KIND_CALL = 2'b01,
    KIND_RET  = 2'b10,
    KIND_JUMP = 2'b11
  } brKind_e;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'b00,
    SEL_BTB    = 2'b01,
    SEL_STATIC = 2'b10,
    SEL_RAS    = 2'b11
  } tgtSel_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
    logic train;
  } fpStrobes_t;

endpackage

// File: rtl/fp_ctrl.sv
module fp_ctrl
  import fp_pkg::*;
(
  input  logic       lookupValid,
  input  logic       brValid,
  input  logic [1:0] brKind,
  input  logic       brBackward,
  input  logic       flush,
  input  logic       retValid,
  input  logic       btbHit,
  input  logic [1:0] btbCtr,
  input  logic       rasEmpty,
  output fpStrobes_t strobes,
  output tgtSel_e    tgtSel,
  output logic       predTaken
);

  logic haveDesc;
  logic isCall;
  logic isRet;

  assign haveDesc = lookupValid && brValid;
  assign isCall   = haveDesc && (brKind == KIND_CALL);
  assign isRet    = haveDesc && (brKind == KIND_RET);

  // direction and target source
  always_comb begin
    predTaken = 1'b0;
    tgtSel    = SEL_SEQ;
    if (isRet) begin
      predTaken = 1'b1;
      if (!rasEmpty)   tgtSel = SEL_RAS;
      else if (btbHit) tgtSel = SEL_BTB;
      else             tgtSel = SEL_SEQ;
    end else if (btbHit) begin
      predTaken = btbCtr[1];
      tgtSel    = btbCtr[1] ? SEL_BTB : SEL_SEQ;
    end else if (haveDesc) begin
      unique case (brKind)
        KIND_COND: predTaken = brBackward;
        KIND_CALL,
        KIND_JUMP: predTaken = 1'b1;
        default:   predTaken = 1'b0;
      endcase
      tgtSel = predTaken ? SEL_STATIC : SEL_SEQ;
    end
  end

  // strobes to the datapath
  always_comb begin
    strobes.clear = flush;
    strobes.push  = isCall && !flush;
    strobes.pop   = isRet && !rasEmpty && !flush;
    strobes.train = retValid;
  end

endmodule

// File: rtl/fp_dpath.sv
module fp_dpath
  import fp_pkg::*;
#(
  parameter int AW          = 16,
  parameter int LENW        = 4,
  parameter int BTB_ENTRIES = 16,
  parameter int RAS_DEPTH   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lookupValid,
  input  logic [AW-1:0]   lookupAddr,
  input  logic [AW-1:0]   brTarget,
  input  logic [LENW-1:0] brLen,
  input  logic [AW-1:0]   retAddr,
  input  logic            retTaken,
  input  logic [AW-1:0]   retTarget,
  input  fpStrobes_t      strobes,
  input  tgtSel_e         tgtSel,
  output logic            btbHit,
  output logic [1:0]      btbCtr,
  output logic            rasEmpty,
  output logic [AW-1:0]   predTarget
);

  localparam int IDXW = $clog2(BTB_ENTRIES);
  localparam int TAGW = AW - IDXW;
  localparam int PTRW = $clog2(RAS_DEPTH);
  localparam int CNTW = $clog2(RAS_DEPTH + 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(RAS_DEPTH);

  // ---------------- target table ----------------
  logic [BTB_ENTRIES-1:0] vld;
  logic [TAGW-1:0]        tagMem [BTB_ENTRIES];
  logic [1:0]             ctrMem [BTB_ENTRIES];
  logic [AW-1:0]          tgtMem [BTB_ENTRIES];

  logic [IDXW-1:0] lkIdx;
  logic [TAGW-1:0] lkTag;
  logic [IDXW-1:0] rtIdx;
  logic [TAGW-1:0] rtTag;
  logic            rtHit;
  logic [1:0]      rtCtrOld;
  logic [1:0]      rtCtrNew;
  logic [AW-1:0]   seqAddr;

  assign lkIdx   = lookupAddr[IDXW-1:0];
  assign lkTag   = lookupAddr[AW-1:IDXW];
  assign rtIdx   = retAddr[IDXW-1:0];
  assign rtTag   = retAddr[AW-1:IDXW];
  assign seqAddr = lookupAddr + AW'(brLen);

  assign btbHit = lookupValid && vld[lkIdx] && (tagMem[lkIdx] == lkTag);
  assign btbCtr = ctrMem[lkIdx];

  assign rtHit    = vld[rtIdx] && (tagMem[rtIdx] == rtTag);
  assign rtCtrOld = ctrMem[rtIdx];

  always_comb begin
    if (!rtHit)
      rtCtrNew = retTaken ? 2'd2 : 2'd1;
    else if (retTaken)
      rtCtrNew = (rtCtrOld == 2'd3) ? 2'd3 : rtCtrOld + 2'd1;
    else
      rtCtrNew = (rtCtrOld == 2'd0) ? 2'd0 : rtCtrOld - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             vld        <= '0;
    else if (strobes.train) vld[rtIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobes.train) begin
      tagMem[rtIdx] <= rtTag;
      ctrMem[rtIdx] <= rtCtrNew;
      if (!rtHit || retTaken) tgtMem[rtIdx] <= retTarget;
    end
  end

  // ---------------- return stack ----------------
  logic [AW-1:0]   rasMem [RAS_DEPTH];
  logic [PTRW-1:0] rasPtr;
  logic [CNTW-1:0] rasCnt;
  logic [AW-1:0]   rasTop;

  assign rasTop   = rasMem[rasPtr - PTRW'(1)];
  assign rasEmpty = (rasCnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.clear) begin
      rasPtr <= '0;
      rasCnt <= '0;
    end else if (strobes.push) begin
      rasPtr <= rasPtr + PTRW'(1);
      rasCnt <= (rasCnt == CNT_FULL) ? rasCnt : rasCnt + CNTW'(1);
    end else if (strobes.pop) begin
      rasPtr <= rasPtr - PTRW'(1);
      rasCnt <= rasCnt - CNTW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push) rasMem[rasPtr] <= seqAddr;
  end

  // ---------------- target mux ----------------
  always_comb begin
    unique case (tgtSel)
      SEL_BTB:    predTarget = tgtMem[lkIdx];
      SEL_STATIC: predTarget = brTarget;
      SEL_RAS:    predTarget = rasTop;
      default:    predTarget = seqAddr;
    endcase
  end

  // ---------------- assertions ----------------
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rasCnt <= CNT_FULL);

  a_r6_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.push && !strobes.clear && rasCnt != CNT_FULL)
      |=> rasCnt == $past(rasCnt) + CNTW'(1));

  a_r6_push_top: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.push && !strobes.clear) |=> rasTop == $past(seqAddr));

  a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clear |=> rasEmpty);

  a_r4_no_train_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.train |=> $stable(vld));

  a_r5_ras_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (tgtSel == SEL_RAS) |-> !rasEmpty);

endmodule

// File: rtl/fetch_predictor.sv
module fetch_predictor
  import fp_pkg::*;
#(
  parameter int AW          = 16,
  parameter int LENW        = 4,
  parameter int BTB_ENTRIES = 16,
  parameter int RAS_DEPTH   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            lookupValid,
  input  logic [AW-1:0]   lookupAddr,
  input  logic            brValid,
  input  logic [1:0]      brKind,
  input  logic            brBackward,
  input  logic [AW-1:0]   brTarget,
  input  logic [LENW-1:0] brLen,
  input  logic            retValid,
  input  logic [AW-1:0]   retAddr,
  input  logic            retTaken,
  input  logic [AW-1:0]   retTarget,
  output logic            predTaken,
  output logic [AW-1:0]   predTarget
);

  fpStrobes_t strobes;
  tgtSel_e    tgtSel;
  logic       btbHit;
  logic [1:0] btbCtr;
  logic       rasEmpty;

  fp_ctrl u_ctrl (
    .lookupValid (lookupValid),
    .brValid     (brValid),
    .brKind      (brKind),
    .brBackward  (brBackward),
    .flush       (flush),
    .retValid    (retValid),
    .btbHit      (btbHit),
    .btbCtr      (btbCtr),
    .rasEmpty    (rasEmpty),
    .strobes     (strobes),
    .tgtSel      (tgtSel),
    .predTaken   (predTaken)
  );

  fp_dpath #(
    .AW          (AW),
    .LENW        (LENW),
    .BTB_ENTRIES (BTB_ENTRIES),
    .RAS_DEPTH   (RAS_DEPTH)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .lookupValid (lookupValid),
    .lookupAddr  (lookupAddr),
    .brTarget    (brTarget),
    .brLen       (brLen),
    .retAddr     (retAddr),
    .retTaken    (retTaken),
    .retTarget   (retTarget),
    .strobes     (strobes),
    .tgtSel      (tgtSel),
    .btbHit      (btbHit),
    .btbCtr      (btbCtr),
    .rasEmpty    (rasEmpty),
    .predTarget  (predTarget)
  );

  // R5: a return is always predicted taken
  a_r5_ret_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (lookupValid && brValid && brKind == KIND_RET) |-> predTaken);

endmodule

// File: tb/fetch_predictor_bench.sv
module fetch_predictor_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        lookupValid;
  logic [15:0] lookupAddr;
  logic        brValid;
  logic [1:0]  brKind;
  logic        brBackward;
  logic [15:0] brTarget;
  logic [3:0]  brLen;
  logic        retValid;
  logic [15:0] retAddr;
  logic        retTaken;
  logic [15:0] retTarget;
  logic        predTaken;
  logic [15:0] predTarget;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  fetch_predictor u_fetch_predictor (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .brValid(brValid), .brKind(brKind), .brBackward(brBackward),
    .brTarget(brTarget), .brLen(brLen),
    .retValid(retValid), .retAddr(retAddr), .retTaken(retTaken),
    .retTarget(retTarget),
    .predTaken(predTaken), .predTarget(predTarget)
  );

  task automatic idle();
    flush = 0; lookupValid = 0; lookupAddr = 0; brValid = 0; brKind = 0;
    brBackward = 0; brTarget = 0; brLen = 4; retValid = 0; retAddr = 0;
    retTaken = 0; retTarget = 0;
  endtask

  task automatic look(input logic [15:0] a, input logic bv, input logic [1:0] k,
                      input logic back, input logic [15:0] t, input logic [3:0] l);
    lookupValid = 1; lookupAddr = a; brValid = bv; brKind = k;
    brBackward = back; brTarget = t; brLen = l;
  endtask

  task automatic retire(input logic [15:0] a, input logic tk, input logic [15:0] t);
    retValid = 1; retAddr = a; retTaken = tk; retTarget = t;
  endtask

  task automatic chk(input string req, input logic expT, input logic [15:0] expA);
    #1;
    total++;
    if (predTaken !== expT || predTarget !== expA) begin
      bad++;
      $display("FAIL %s: got taken=%0b target=%h, expected taken=%0b target=%h",
               req, predTaken, predTarget, expT, expA);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got running, expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [15:0] x;
    int          ctr;
    logic [15:0] curTgt;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1, R3: empty table, static rule over every index
    for (int i = 0; i < 16; i++) begin
      a = 16'h1230 + 16'(i);
      tick(); look(a, 0, 2'b00, 0, 16'h0, 4);          chk("R1 reset miss", 0, a + 16'd4);
      tick(); look(a, 1, 2'b00, 0, a + 16'h40, 4);     chk("R3 cond fwd", 0, a + 16'd4);
      tick(); look(a, 1, 2'b00, 1, a - 16'h80, 4);     chk("R3 cond back", 1, a - 16'h80);
      tick(); look(a, 1, 2'b11, 0, a + 16'h100, 2);    chk("R3 jump", 1, a + 16'h100);
      tick(); look(a, 1, 2'b01, 0, a + 16'h200, 3);    chk("R3 call", 1, a + 16'h200);
    end
    tick(); flush = 1;

    // R4, R2: allocate every index taken, check hit and tag mismatch
    for (int i = 0; i < 16; i++) begin
      a = 16'hA000 + 16'(i);
      tick(); retire(a, 1, 16'h5000 + 16'(i * 16));
      tick(); look(a, 0, 2'b00, 0, 16'h0, 4);          chk("R4 alloc taken", 1, 16'h5000 + 16'(i * 16));
      tick(); look(16'hB000 + 16'(i), 1, 2'b00, 0, 16'h0, 4);
      chk("R1 tag mismatch", 0, 16'hB000 + 16'(i) + 16'd4);
    end

    // R4, R2: counter walk on index 3
    a = 16'hA003; ctr = 2; curTgt = 16'h5030;
    for (int s = 0; s < 9; s++) begin
      logic tk;
      tk = (s >= 3 && s <= 6);
      tick(); retire(a, tk, 16'h6000 + 16'(s));
      if (tk) begin
        ctr = (ctr == 3) ? 3 : ctr + 1;
        curTgt = 16'h6000 + 16'(s);
      end else begin
        ctr = (ctr == 0) ? 0 : ctr - 1;
      end
      tick(); look(a, 1, 2'b00, 1, 16'h0100, 4);
      if (ctr >= 2) chk("R2 counter taken", 1, curTgt);
      else          chk("R2 counter not taken", 0, a + 16'd4);
    end

    // R4: not-taken allocation overrides static backward rule
    tick(); retire(16'hD007, 0, 16'h7777);
    tick(); look(16'hD007, 1, 2'b00, 1, 16'h0010, 4);  chk("R4 alloc not taken", 0, 16'hD00B);

    // R10: same-cycle retire and lookup on one index
    x = 16'h4440;
    tick(); retire(16'hC005, 1, x); look(16'hC005, 0, 2'b00, 0, 16'h0, 4);
    chk("R10 old entry seen", 0, 16'hC009);
    tick(); look(16'hC005, 0, 2'b00, 0, 16'h0, 4);     chk("R10 write visible", 1, x);

    // R8: empty stack fallbacks
    tick(); look(16'h3000, 1, 2'b10, 0, 16'h0, 1);     chk("R8 empty miss", 1, 16'h3001);
    tick(); look(16'hC005, 1, 2'b10, 0, 16'h0, 1);     chk("R8 empty hit", 1, x);

    // R7: ten calls, eight returns, then empty
    for (int i = 0; i < 10; i++) begin
      tick(); look(16'h2000 + 16'(i * 16), 1, 2'b01, 0, 16'h9000, 5);
    end
    for (int k = 0; k < 8; k++) begin
      tick(); look(16'h3000, 1, 2'b10, 0, 16'h0, 1);
      chk("R7 wrap return", 1, 16'h2005 + 16'((9 - k) * 16));
    end
    tick(); look(16'h3000, 1, 2'b10, 0, 16'h0, 1);     chk("R7 drained", 1, 16'h3001);

    // R6: nested calls and returns
    tick(); look(16'h2400, 1, 2'b01, 0, 16'h9000, 2);
    tick(); look(16'h2500, 1, 2'b01, 0, 16'h9000, 3);
    tick(); look(16'h3000, 1, 2'b10, 0, 16'h0, 1);     chk("R6 inner", 1, 16'h2503);
    tick(); look(16'h2600, 1, 2'b01, 0, 16'h9000, 4);
    tick(); look(16'h3000, 1, 2'b10, 0, 16'h0, 1);     chk("R6 second", 1, 16'h2604);
    tick(); look(16'h3000, 1, 2'b10, 0, 16'h0, 1);     chk("R6 outer", 1, 16'h2402);

    // R9: flush empties stack, drops same-cycle call, keeps table
    tick(); look(16'h2100, 1, 2'b01, 0, 16'h9000, 2);
    tick(); look(16'h2200, 1, 2'b01, 0, 16'h9000, 2); flush = 1;
    tick(); look(16'h3000, 1, 2'b10, 0, 16'h0, 1);     chk("R9 stack empty", 1, 16'h3001);
    tick(); look(16'hC005, 0, 2'b00, 0, 16'h0, 4);     chk("R9 table kept", 1, x);

    // R5: return with non-empty stack beats a table hit
    tick(); look(16'h2700, 1, 2'b01, 0, 16'h9000, 6);
    tick(); look(16'hC005, 1, 2'b10, 0, 16'h0, 1);     chk("R5 stack over table", 1, 16'h2706);

    tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule